// File: doc/BRIEF.md
# Hibernation Power Sequencer with Wake

This block steers a device into and out of a low-power hibernate state. Software raises a one-cycle request. The sequencer then asserts an active-high output, which tells an external regulator to remove main power. It holds that output until a wake event arrives, then releases it so that the regulator restores power.

A seconds counter runs the whole time from the block's own slow clock. A prescaler turns that clock into a one-per-second tick. The prescaler divides by one of two powers of two, chosen by a select pin, so that either a low-frequency source or a high-frequency source can feed it.

Two wake sources exist: an external pin and a programmable seconds match. A wake-cause register records which of them ended hibernation, and it can record both. Entry is refused in two cases:
- A low-battery indication is present while the battery veto is enabled. This case also raises a sticky flag.
- A wake condition is already present when the request arrives.

All control and status pins are plain levels or pulses; the block has no streaming data path. The whole block runs on the slow clock, so software-side inputs must be presented synchronously to that clock.

Top module: `hib_seq`

## Requirements
- R1: After reset, hib_out, wake_cause, entry_refused and rtc_sec are all zero.
- R2: A hib_req pulse in the active state, with no veto and no wake condition present, raises hib_out at the next rising edge. hib_out then stays high until a wake occurs, and further requests have no effect on it.
- R3: wake_pin passes through a two-flop synchronizer. If the pin rises before rising edge N, hib_out falls at edge N+2, and wake_cause bit 0 (pin) is set.
- R4: rtc_sec increments by one every 2^LO_W cycles when clk_sel is 0, and every 2^HI_W cycles when clk_sel is 1.
- R5: With match_en set, the tick on which rtc_sec becomes equal to match_val ends hibernation on the next edge. wake_cause bit 1 (RTC) is set, and rtc_sec equals match_val when hib_out falls.
- R6: With match_en clear, rtc_sec reaching match_val has no effect on hib_out.
- R7: A request while batt_low and veto_en are both high leaves the block active and sets entry_refused. With veto_en low, batt_low does not block entry.
- R8: A request made while the synchronized wake pin is high, or while match_en is set and rtc_sec already equals match_val, is ignored. The block stays active and no flag changes.
- R9: When the pin and the RTC match arrive in the same cycle, wake_cause becomes 2'b11.
- R10: A status_clr pulse clears wake_cause and entry_refused on the next edge. wake_cause and entry_refused otherwise stay set until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow RTC clock that clocks the whole block |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 1 | 0: divide by 2^LO_W; 1: divide by 2^HI_W |
| hib_req | input | 1 | One-cycle hibernate request |
| wake_pin | input | 1 | Asynchronous external wake, active high |
| match_en | input | 1 | Enables the seconds-match wake |
| match_val | input | SEC_W | Seconds value that causes a wake |
| batt_low | input | 1 | Low-battery indication |
| veto_en | input | 1 | Enables refusal of entry on low battery |
| status_clr | input | 1 | Clears wake_cause and entry_refused |
| hib_out | output | 1 | High while hibernating (regulator off) |
| wake_cause | output | 2 | Bit 1: RTC match, bit 0: pin |
| entry_refused | output | 1 | Sticky flag for a refused entry on low battery |
| rtc_sec | output | SEC_W | Running seconds count |

## Verification
The hardest case to reach is the pin and the RTC match arriving together, because whichever source comes first ends hibernation alone. The bench tracks the phase of the prescaler by watching rtc_sec change to one below the match value. It then counts edges and raises wake_pin exactly two edges before the match tick, so that the synchronizer output and the registered match hit become valid at the same edge. The bench overrides the prescaler widths to small values so that both dividers can be measured in a short run.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic {ST_ACTIVE = 1'b0, ST_HIB = 1'b1} hib_state_e;
  typedef struct packed {
    logic rtc;
    logic pin;
  } wake_src_t;
endpackage

// File: rtl/hib_sync.sv
module hib_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic stg1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1     <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      stg1     <= async_in;
      sync_out <= stg1;
    end
  end
endmodule

// File: rtl/hib_prescaler.sv
module hib_prescaler #(
  parameter int LO_W = 15,
  parameter int HI_W = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic tick
);
  localparam int CW = (HI_W > LO_W) ? HI_W : LO_W;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (sel) tick = &cnt[HI_W-1:0];
    else     tick = &cnt[LO_W-1:0];
  end

  // R4: ticks never come on consecutive cycles
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/hib_rtc.sv
module hib_rtc #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             match_en,
  input  logic [SEC_W-1:0] match_val,
  output logic [SEC_W-1:0] sec,
  output logic             match_hit,
  output logic             match_level
);
  logic [SEC_W-1:0] sec_nxt;
  assign sec_nxt = sec + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec       <= '0;
      match_hit <= 1'b0;
    end else begin
      if (tick) sec <= sec_nxt;
      match_hit <= match_en && tick && (sec_nxt == match_val);
    end
  end

  assign match_level = match_en && (sec == match_val);

  a_r4_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sec == $past(sec) + 1'b1));
  a_r4_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sec));
  a_r5_hit_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> (sec == match_val));
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hib_req,
  input  logic       pin_s,
  input  logic       match_hit,
  input  logic       match_level,
  input  logic       batt_low,
  input  logic       veto_en,
  input  logic       status_clr,
  output logic       hib_out,
  output wake_src_t  cause,
  output logic       refused
);
  hib_state_e state, state_nxt;
  logic veto, refuse, wake_ev, enter;

  always_comb begin
    veto      = veto_en && batt_low;
    refuse    = (state == ST_ACTIVE) && hib_req && veto;
    enter     = (state == ST_ACTIVE) && hib_req && !veto && !pin_s && !match_level;
    wake_ev   = (state == ST_HIB) && (pin_s || match_hit);
    state_nxt = state;
    if (enter)   state_nxt = ST_HIB;
    if (wake_ev) state_nxt = ST_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_ACTIVE;
      cause   <= '0;
      refused <= 1'b0;
    end else begin
      state <= state_nxt;
      if (status_clr) begin
        cause   <= '0;
        refused <= 1'b0;
      end
      if (wake_ev) begin
        cause.pin <= (status_clr ? 1'b0 : cause.pin) | pin_s;
        cause.rtc <= (status_clr ? 1'b0 : cause.rtc) | match_hit;
      end
      if (refuse) refused <= 1'b1;
    end
  end

  assign hib_out = (state == ST_HIB);

  a_r7_veto_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!hib_out && hib_req && batt_low && veto_en) |=> (!hib_out && refused));
  a_r3_pin_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_out && pin_s) |=> (!hib_out && cause.pin));
  a_r5_match_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_out && match_hit) |=> (!hib_out && cause.rtc));
  a_r8_no_entry_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!hib_out && (pin_s || match_level)) |=> !hib_out);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !hib_out) |=> (cause == '0));
endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_pkg::*;
#(
  parameter int LO_W  = 15,
  parameter int HI_W  = 22,
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel,
  input  logic             hib_req,
  input  logic             wake_pin,
  input  logic             match_en,
  input  logic [SEC_W-1:0] match_val,
  input  logic             batt_low,
  input  logic             veto_en,
  input  logic             status_clr,
  output logic             hib_out,
  output logic [1:0]       wake_cause,
  output logic             entry_refused,
  output logic [SEC_W-1:0] rtc_sec
);
  logic tick, pin_s, match_hit, match_level;
  wake_src_t cause;

  hib_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wake_pin), .sync_out(pin_s)
  );

  hib_prescaler #(.LO_W(LO_W), .HI_W(HI_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
  );

  hib_rtc #(.SEC_W(SEC_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match_en(match_en),
    .match_val(match_val), .sec(rtc_sec), .match_hit(match_hit),
    .match_level(match_level)
  );

  hib_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hib_req(hib_req), .pin_s(pin_s),
    .match_hit(match_hit), .match_level(match_level), .batt_low(batt_low),
    .veto_en(veto_en), .status_clr(status_clr), .hib_out(hib_out),
    .cause(cause), .refused(entry_refused)
  );

  assign wake_cause = cause;
endmodule

// File: tb/hib_seq_bench.sv
`timescale 1ns/1ps
module hib_seq_bench;
  localparam int LO_W = 3, HI_W = 5, SEC_W = 8;
  logic clk = 0, rst_n = 0;
  logic clk_sel = 0, hib_req = 0, wake_pin = 0, match_en = 0;
  logic [SEC_W-1:0] match_val = '0;
  logic batt_low = 0, veto_en = 0, status_clr = 0;
  logic hib_out, entry_refused;
  logic [1:0] wake_cause;
  logic [SEC_W-1:0] rtc_sec;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  hib_seq #(.LO_W(LO_W), .HI_W(HI_W), .SEC_W(SEC_W)) u_hib_seq (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .hib_req(hib_req),
    .wake_pin(wake_pin), .match_en(match_en), .match_val(match_val),
    .batt_low(batt_low), .veto_en(veto_en), .status_clr(status_clr),
    .hib_out(hib_out), .wake_cause(wake_cause),
    .entry_refused(entry_refused), .rtc_sec(rtc_sec)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) hib_req = 1;
    @(negedge clk) hib_req = 0;
  endtask

  task automatic clear_status();
    @(negedge clk) status_clr = 1;
    @(negedge clk) status_clr = 0;
  endtask

  task automatic wait_wake(output int cyc);
    cyc = 0;
    while (hib_out && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    check(hib_out == 0, "R1 hib_out", hib_out, 0);
    check(wake_cause == 0, "R1 cause", wake_cause, 0);
    check(entry_refused == 0, "R1 refused", entry_refused, 0);
    check(rtc_sec == 0, "R1 sec", rtc_sec, 0);
  endtask

  task automatic t_tick();
    int n;
    logic [SEC_W-1:0] s;
    clk_sel = 0;
    s = rtc_sec; while (rtc_sec == s) @(negedge clk);
    s = rtc_sec; n = 0;
    while (rtc_sec == s) begin @(negedge clk); n++; end
    check(n == (1 << LO_W), "R4 low divider", n, 1 << LO_W);
    clk_sel = 1;
    s = rtc_sec; while (rtc_sec == s) @(negedge clk);
    s = rtc_sec; n = 0;
    while (rtc_sec == s) begin @(negedge clk); n++; end
    check(n == (1 << HI_W), "R4 high divider", n, 1 << HI_W);
    clk_sel = 0;
    s = rtc_sec; while (rtc_sec == s) @(negedge clk);
  endtask

  task automatic t_pin_wake();
    match_en = 0;
    pulse_req();
    check(hib_out == 1, "R2 enter", hib_out, 1);
    repeat (5) @(negedge clk);
    pulse_req();
    check(hib_out == 1, "R2 stays high", hib_out, 1);
    wake_pin = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(hib_out == 1, "R3 two edges still high", hib_out, 1);
    @(negedge clk);
    check(hib_out == 0, "R3 third edge low", hib_out, 0);
    check(wake_cause == 2'b01, "R3 cause pin", wake_cause, 1);
    repeat (3) @(negedge clk);
    check(wake_cause == 2'b01, "R10 cause sticky", wake_cause, 1);
    wake_pin = 0;
    repeat (3) @(negedge clk);
    clear_status();
    check(wake_cause == 0, "R10 cause cleared", wake_cause, 0);
  endtask

  task automatic t_match_wake();
    int c;
    match_val = rtc_sec + 8'd3;
    match_en = 1;
    pulse_req();
    check(hib_out == 1, "R5 entered", hib_out, 1);
    wait_wake(c);
    check(hib_out == 0, "R5 woke", hib_out, 0);
    check(rtc_sec == match_val, "R5 sec at wake", rtc_sec, match_val);
    check(wake_cause == 2'b10, "R5 cause rtc", wake_cause, 2);
    pulse_req();
    check(hib_out == 0, "R8 match level blocks", hib_out, 0);
    check(wake_cause == 2'b10, "R8 flags unchanged", wake_cause, 2);
    clear_status();
  endtask

  task automatic t_match_off();
    int c;
    match_en = 0;
    match_val = rtc_sec + 8'd2;
    pulse_req();
    repeat (5 << LO_W) @(negedge clk);
    check(hib_out == 1, "R6 no match wake", hib_out, 1);
    wake_pin = 1;
    wait_wake(c);
    check(wake_cause == 2'b01, "R6 pin only", wake_cause, 1);
    pulse_req();
    check(hib_out == 0, "R8 pin level blocks", hib_out, 0);
    wake_pin = 0;
    repeat (3) @(negedge clk);
    clear_status();
  endtask

  task automatic t_veto();
    batt_low = 1; veto_en = 1;
    pulse_req();
    check(hib_out == 0, "R7 vetoed", hib_out, 0);
    check(entry_refused == 1, "R7 refused flag", entry_refused, 1);
    clear_status();
    check(entry_refused == 0, "R10 refused cleared", entry_refused, 0);
    veto_en = 0;
    pulse_req();
    check(hib_out == 1, "R7 no veto enters", hib_out, 1);
    check(entry_refused == 0, "R7 flag stays clear", entry_refused, 0);
    wake_pin = 1;
    repeat (4) @(negedge clk);
    wake_pin = 0; batt_low = 0;
    repeat (3) @(negedge clk);
    clear_status();
  endtask

  task automatic t_both();
    logic [SEC_W-1:0] m;
    m = rtc_sec + 8'd3;
    match_val = m; match_en = 1;
    pulse_req();
    while (rtc_sec != m - 8'd1) @(negedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk) wake_pin = 1;
    repeat (4) @(negedge clk);
    check(hib_out == 0, "R9 woke", hib_out, 0);
    check(wake_cause == 2'b11, "R9 both causes", wake_cause, 3);
    wake_pin = 0; match_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tick();
    t_pin_wake();
    t_match_wake();
    t_match_off();
    t_veto();
    t_both();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule